// File: doc/BRIEF.md
# Buffered serial port with threshold interrupts

This block is an asynchronous serial transceiver for 8-bit characters with one start bit, no parity and one stop bit. A single holding register sits in front of the transmit shift register. A two-entry queue collects received characters. Software drives the block through four byte-wide registers: control, status, transmit data and receive data. A single interrupt line summarises two events.

The first event, the transmit-empty event, fires when a held character moves into the shift register. At that point software may refill the holding register while the character is still on the line. The second event, the receive-full event, fires when the receive queue reaches a threshold that software selects: one character or two.

Timing comes from the `baud_tick` input, which pulses at sixteen times the bit rate. Each bit lasts sixteen ticks. The receiver checks the start bit at its midpoint and then samples each further bit at its midpoint.

Top module: `uart_bufirq`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read 0, `irq` is low and `txd` is high.
- R2: While the enable bit (control bit 0) is 0, `txd` stays high, writes to the transmit data register (address 2) are ignored and the receiver ignores `rxd`.
- R3: A byte written to address 2 while the block is enabled is sent LSB first. The frame is a low start bit, then the data bits, then a high stop bit, and each bit lasts OVERSAMPLE ticks. The busy flag (status bit 2) is 1 while a frame is being shifted out.
- R4: When a held byte moves into the shift register, the transmit-empty condition sets. `irq` follows it while the transmit interrupt enable (control bit 1) is 1. A write to address 2 clears the condition.
- R5: Received bytes enter a two-entry queue. A read of address 3 returns and removes the oldest byte. Status bit 0 is 1 when one or more bytes are queued, and status bit 1 is 1 when two bytes are queued.
- R6: With the threshold select (control bit 3) at 0 and the receive interrupt enable (control bit 2) at 1, `irq` is high whenever one or more bytes are queued.
- R7: With the threshold select at 1, the receive condition raises `irq` only while two bytes are queued.
- R8: With the receive interrupt enable at 0, queued bytes never raise `irq`.
- R9: A byte that completes while the queue is full is discarded and sets the sticky overrun flag (status bit 3). Writing 1 to status bit 3 clears the flag.
- R10: A low pulse on `rxd` that has returned high by the middle of the start bit is rejected, and no byte is queued.
- R11: Writing 0 to the enable bit aborts the current frame and empties the transmit holding register. Re-enabling the block then sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Sampling tick, one pulse per 1/OVERSAMPLE of a bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 3 pops the queue) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases:
- The threshold of two. A design that ignored it would raise `irq` after the first byte.
- A third byte arriving while the queue is full. A design that let it overwrite a queued byte would return the wrong data, and one without the overrun flag would read status 3 instead of 11.
- A short glitch on `rxd`. A receiver that did not check the start bit at its midpoint would queue a phantom byte.
- Disabling the block while a second byte waits in the holding register. A design that kept that byte would send it after re-enable.
- The transmit-empty event, which must appear when the shift register loads and clear on the next data write. A design that tied it to line idle would assert it a full frame late.

// File: rtl/uart_bufirq_pkg.sv
package uart_bufirq_pkg;
   typedef enum logic [1:0] {
      ADR_CTRL = 2'd0,
      ADR_STAT = 2'd1,
      ADR_TXD  = 2'd2,
      ADR_RXD  = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic rx_thr2;
      logic rx_ie;
      logic tx_ie;
      logic en;
   } ctrl_t;

   typedef enum logic [1:0] {
      RXS_IDLE,
      RXS_START,
      RXS_DATA,
      RXS_STOP
   } rx_state_e;
endpackage

// File: rtl/uart_bufirq_tx.sv
module uart_bufirq_tx #(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic              txd,
   output logic              busy,
   output logic              load
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int CNT_W   = $clog2(OVERSAMPLE);
   localparam int BITS_W  = $clog2(FRAME_W + 1);

   logic              hold_valid;
   logic [DATA_W-1:0] hold_data;
   logic              shifting;
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]  tick_cnt;
   logic [BITS_W-1:0] bit_cnt;

   assign load = en & hold_valid & ~shifting;
   assign txd  = shifting ? shreg[0] : 1'b1;
   assign busy = shifting;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_data  <= '0;
         shifting   <= 1'b0;
         shreg      <= '1;
         tick_cnt   <= '0;
         bit_cnt    <= '0;
      end else if (!en) begin
         hold_valid <= 1'b0;
         shifting   <= 1'b0;
         tick_cnt   <= '0;
         bit_cnt    <= '0;
      end else begin
         if (load) begin
            shifting <= 1'b1;
            shreg    <= {1'b1, hold_data, 1'b0};
            tick_cnt <= '0;
            bit_cnt  <= '0;
         end else if (shifting && tick) begin
            if (tick_cnt == CNT_W'(OVERSAMPLE - 1)) begin
               tick_cnt <= '0;
               shreg    <= {1'b1, shreg[FRAME_W-1:1]};
               if (bit_cnt == BITS_W'(FRAME_W - 1)) shifting <= 1'b0;
               else                                 bit_cnt  <= bit_cnt + 1'b1;
            end else begin
               tick_cnt <= tick_cnt + 1'b1;
            end
         end
         if (wr_stb) begin
            hold_valid <= 1'b1;
            hold_data  <= wr_data;
         end else if (load) begin
            hold_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/uart_bufirq_rx.sv
module uart_bufirq_rx
   import uart_bufirq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              rxd,
   output logic              byte_valid,
   output logic [DATA_W-1:0] byte_data
);
   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int HALF  = OVERSAMPLE / 2;
   localparam int BIT_W = $clog2(DATA_W);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q <= 1'b1;
            else        sync_q <= rxd;
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      end
   endgenerate
   assign rx_s = sync_q[SYNC_STAGES-1];

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic [DATA_W-1:0] shreg;

   assign byte_data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RXS_IDLE;
         cnt        <= '0;
         bitn       <= '0;
         shreg      <= '0;
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         if (!en) begin
            state <= RXS_IDLE;
         end else if (tick) begin
            case (state)
               RXS_IDLE: if (!rx_s) begin
                  state <= RXS_START;
                  cnt   <= '0;
               end
               RXS_START: if (cnt == CNT_W'(HALF - 1)) begin
                  cnt <= '0;
                  if (rx_s) state <= RXS_IDLE;
                  else begin
                     state <= RXS_DATA;
                     bitn  <= '0;
                  end
               end else cnt <= cnt + 1'b1;
               RXS_DATA: if (cnt == CNT_W'(OVERSAMPLE - 1)) begin
                  cnt   <= '0;
                  shreg <= {rx_s, shreg[DATA_W-1:1]};
                  if (bitn == BIT_W'(DATA_W - 1)) state <= RXS_STOP;
                  else                            bitn  <= bitn + 1'b1;
               end else cnt <= cnt + 1'b1;
               RXS_STOP: if (cnt == CNT_W'(OVERSAMPLE - 1)) begin
                  cnt        <= '0;
                  state      <= RXS_IDLE;
                  byte_valid <= rx_s;
               end else cnt <= cnt + 1'b1;
               default: state <= RXS_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_bufirq_rxfifo.sv
module uart_bufirq_rxfifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              overrun_evt
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              full, do_push, do_pop;

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full        = (count == CNT_W'(DEPTH));
   assign do_pop      = pop & (count != '0);
   assign do_push     = push & (~full | do_pop);
   assign overrun_evt = push & full & ~do_pop;
   assign head        = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (do_push) begin
            mem[wr_ptr] <= push_data;
            wr_ptr      <= ptr_next(wr_ptr);
         end
         if (do_pop) rd_ptr <= ptr_next(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/uart_bufirq.sv
module uart_bufirq
   import uart_bufirq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int RX_DEPTH    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              rxd,
   output logic              txd,
   output logic              irq
);
   localparam int RXC_W = $clog2(RX_DEPTH + 1);

   generate
      if (DATA_W < 5)               begin : g_bad_w  $error("DATA_W must be 5 or more"); end
      if (OVERSAMPLE < 4)           begin : g_bad_os $error("OVERSAMPLE must be 4 or more"); end
      if (RX_DEPTH < 2)             begin : g_bad_d  $error("RX_DEPTH must be 2 or more"); end
      if (SYNC_STAGES < 1)          begin : g_bad_s  $error("SYNC_STAGES must be 1 or more"); end
   endgenerate

   ctrl_t              ctrl_q;
   logic               xfer_en, tx_ie, rx_ie, rx_thr2;
   logic               txe_flag, overrun;
   logic               tx_wr, tx_busy, tx_load;
   logic               rx_push, rx_pop, ovr_evt;
   logic [DATA_W-1:0]  rx_byte, rx_head;
   logic [RXC_W-1:0]   rx_count;
   logic               rx_one, rx_two, rx_cond;

   assign xfer_en = ctrl_q.en;
   assign tx_ie   = ctrl_q.tx_ie;
   assign rx_ie   = ctrl_q.rx_ie;
   assign rx_thr2 = ctrl_q.rx_thr2;

   assign tx_wr  = reg_wr & (reg_addr == ADR_TXD);
   assign rx_pop = reg_rd & (reg_addr == ADR_RXD);

   uart_bufirq_tx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(xfer_en), .tick(baud_tick),
      .wr_stb(tx_wr), .wr_data(reg_wdata),
      .txd(txd), .busy(tx_busy), .load(tx_load)
   );

   uart_bufirq_rx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(xfer_en), .tick(baud_tick), .rxd(rxd),
      .byte_valid(rx_push), .byte_data(rx_byte)
   );

   uart_bufirq_rxfifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_byte),
      .pop(rx_pop), .head(rx_head), .count(rx_count), .overrun_evt(ovr_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         txe_flag <= 1'b0;
         overrun  <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == ADR_CTRL) ctrl_q <= ctrl_t'(reg_wdata[3:0]);
         if (tx_wr)        txe_flag <= 1'b0;
         else if (tx_load) txe_flag <= 1'b1;
         if (ovr_evt)                                          overrun <= 1'b1;
         else if (reg_wr && reg_addr == ADR_STAT && reg_wdata[3]) overrun <= 1'b0;
      end
   end

   assign rx_one  = (rx_count != '0);
   assign rx_two  = (rx_count >= RXC_W'(2));
   assign rx_cond = rx_thr2 ? rx_two : rx_one;
   assign irq     = (txe_flag & tx_ie) | (rx_cond & rx_ie);

   always_comb begin
      case (reg_addr)
         ADR_CTRL: reg_rdata = DATA_W'(ctrl_q);
         ADR_STAT: reg_rdata = DATA_W'({overrun, tx_busy, rx_two, rx_one});
         ADR_RXD:  reg_rdata = rx_one ? rx_head : '0;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/uart_bufirq_chk.sv
module uart_bufirq_chk #(
   parameter int DEPTH = 2,
   parameter int CNT_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             txd,
   input logic             tx_busy,
   input logic             tx_load,
   input logic             tx_wr,
   input logic             txe_flag,
   input logic             tx_ie,
   input logic             rx_ie,
   input logic             rx_thr2,
   input logic [CNT_W-1:0] rx_count,
   input logic             push,
   input logic             pop,
   input logic             overrun,
   input logic             irq
);
   a_r2_line_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> txd);
   a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);
   a_r4_txe_set: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load && !tx_wr |=> txe_flag);
   a_r5_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
      pop && !push && rx_count != '0 |=> $past(rx_count) == rx_count + CNT_W'(1));
   a_r6_one_enough: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ie && !rx_thr2 && rx_count != '0 |-> irq);
   a_r7_two_needed: assert property (@(posedge clk) disable iff (!rst_n)
      rx_thr2 && rx_count < CNT_W'(2) && !(txe_flag && tx_ie) |-> !irq);
   a_r8_rx_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ie && !(txe_flag && tx_ie) |-> !irq);
   a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      push && rx_count == CNT_W'(DEPTH) && !pop |=> overrun);
endmodule

bind uart_bufirq uart_bufirq_chk #(.DEPTH(RX_DEPTH), .CNT_W(RXC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(xfer_en), .txd(txd), .tx_busy(tx_busy),
   .tx_load(tx_load), .tx_wr(tx_wr), .txe_flag(txe_flag), .tx_ie(tx_ie),
   .rx_ie(rx_ie), .rx_thr2(rx_thr2), .rx_count(rx_count), .push(rx_push),
   .pop(rx_pop), .overrun(overrun), .irq(irq)
);

// File: tb/uart_bufirq_bench.sv
module uart_bufirq_bench;
   localparam int OS       = 16;
   localparam int TICK_DIV = 2;
   localparam int BITC     = OS * TICK_DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       rxd = 1'b1;
   logic       txd, irq;
   int         errs = 0, checks = 0;
   int         tdiv = 0;

   uart_bufirq u_uart_bufirq (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd), .irq(irq)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      baud_tick <= (tdiv == TICK_DIV - 1);
   end

   function automatic logic [7:0] exp_stat(int cnt, bit busy, bit ovr);
      return {4'b0, ovr, busy, cnt >= 2, cnt >= 1};
   endfunction

   function automatic bit exp_rx_irq(bit ie, bit thr2, int cnt);
      return ie && (thr2 ? cnt >= 2 : cnt >= 1);
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wclk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic send(logic [7:0] b);
      @(negedge clk);
      rxd = 1'b0; wclk(BITC);
      for (int i = 0; i < 8; i++) begin rxd = b[i]; wclk(BITC); end
      rxd = 1'b1; wclk(BITC);
   endtask

   task automatic capture(output logic [7:0] b, output bit ok);
      int t = 0;
      ok = 1'b1; b = '0;
      while (txd !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
      if (t >= 4000) begin ok = 1'b0; return; end
      wclk(BITC / 2);
      if (txd !== 1'b0) ok = 1'b0;
      for (int i = 0; i < 8; i++) begin wclk(BITC); b[i] = txd; end
      wclk(BITC);
      if (txd !== 1'b1) ok = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [7:0] d, b1, b2;
      bit ok1, ok2;
      int lows;
      void'($urandom(32'h5eed_0042));
      wclk(5); rst_n = 1'b1; wclk(2);

      // R1 reset state
      rd(2'd0, d); check("R1 ctrl", d, 0);
      rd(2'd1, d); check("R1 stat", d, 0);
      check("R1 irq", irq, 0);
      check("R1 txd", txd, 1);

      // R2 disabled: tx write and rx line ignored
      wr(2'd2, 8'hA5);
      lows = 0;
      for (int i = 0; i < 100; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      check("R2 txd idle while off", lows, 0);
      send(8'h3C); wclk(4);
      rd(2'd1, d); check("R2 rx ignored", d, 0);
      wr(2'd0, 8'h01);
      lows = 0;
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      check("R2 stale write not sent", lows, 0);

      // R5 R6 threshold one
      wr(2'd0, 8'h05);
      send(8'h3C); wclk(4);
      rd(2'd1, d); check("R5 one ready", d, exp_stat(1, 0, 0));
      check("R6 irq one byte", irq, 1);
      rd(2'd3, d); check("R5 data", d, 8'h3C);
      rd(2'd1, d); check("R5 empty after pop", d, 0);
      check("R6 irq drops", irq, 0);

      // R7 threshold two
      wr(2'd0, 8'h0D);
      send(8'h81); wclk(4);
      check("R7 no irq at one", irq, 0);
      send(8'h7E); wclk(4);
      rd(2'd1, d); check("R5 two ready", d, exp_stat(2, 0, 0));
      check("R7 irq at two", irq, 1);
      rd(2'd3, d); check("R5 oldest first", d, 8'h81);
      check("R7 irq off at one", irq, 0);
      rd(2'd3, d); check("R5 second", d, 8'h7E);

      // R8 masked
      wr(2'd0, 8'h01);
      send(8'h55); wclk(4);
      check("R8 masked irq", irq, 0);
      rd(2'd3, d); check("R8 data", d, 8'h55);

      // R9 overrun
      send(8'h11); send(8'h22); send(8'h33); wclk(4);
      rd(2'd1, d); check("R9 overrun stat", d, exp_stat(2, 0, 1));
      rd(2'd3, d); check("R9 keep first", d, 8'h11);
      rd(2'd3, d); check("R9 keep second", d, 8'h22);
      rd(2'd1, d); check("R9 sticky", d, exp_stat(0, 0, 1));
      wr(2'd1, 8'h08);
      rd(2'd1, d); check("R9 w1c", d, 0);

      // R10 glitch
      @(negedge clk); rxd = 1'b0; wclk(6); rxd = 1'b1; wclk(BITC * 11);
      rd(2'd1, d); check("R10 glitch rejected", d, 0);
      send(8'h9A); wclk(4);
      rd(2'd3, d); check("R10 recovers", d, 8'h9A);

      // R3 R4 transmit and tx-empty event
      wr(2'd0, 8'h03);
      check("R4 irq before load", irq, 0);
      wr(2'd2, 8'hC3);
      fork
         begin capture(b1, ok1); capture(b2, ok2); end
         begin
            wclk(3);
            check("R4 irq on load", irq, 1);
            rd(2'd1, d); check("R3 busy", d, exp_stat(0, 1, 0));
            wr(2'd2, 8'h5A);
            check("R4 cleared by write", irq, 0);
         end
      join
      check("R3 frame1 ok", ok1, 1);
      check("R3 byte1", b1, 8'hC3);
      check("R3 frame2 ok", ok2, 1);
      check("R3 byte2", b2, 8'h5A);
      check("R4 set again", irq, 1);
      wclk(BITC);
      rd(2'd1, d); check("R3 idle after", d, 0);

      // R11 disable flushes
      wr(2'd0, 8'h01);
      wr(2'd2, 8'hF0); wclk(40);
      wr(2'd2, 8'h0F);
      wr(2'd0, 8'h00); wclk(2);
      rd(2'd1, d); check("R11 busy cleared", d, 0);
      check("R11 txd high", txd, 1);
      wr(2'd0, 8'h01);
      lows = 0;
      for (int i = 0; i < BITC * 12; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      check("R11 nothing sent", lows, 0);

      // random receive with random threshold (R5 R6 R7)
      for (int it = 0; it < 10; it++) begin
         logic [7:0] x0, x1;
         bit thr; int nb;
         x0 = 8'($urandom); x1 = 8'($urandom);
         thr = 1'($urandom); nb = 1 + int'($urandom % 2);
         wr(2'd0, {4'b0, thr, 3'b101});
         send(x0);
         if (nb == 2) send(x1);
         wclk(4);
         check(thr ? "R7 rand irq" : "R6 rand irq", irq, exp_rx_irq(1, thr, nb));
         rd(2'd1, d); check("R5 rand stat", d, exp_stat(nb, 0, 0));
         rd(2'd3, d); check("R5 rand d0", d, x0);
         if (nb == 2) begin rd(2'd3, d); check("R5 rand d1", d, x1); end
      end

      // random transmit (R3)
      wr(2'd0, 8'h01);
      for (int it = 0; it < 4; it++) begin
         logic [7:0] x;
         x = 8'($urandom);
         wr(2'd2, x);
         capture(b1, ok1);
         check("R3 rand frame", ok1, 1);
         check("R3 rand byte", b1, x);
         wclk(BITC);
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule